// File: doc/BRIEF.md
# Asymmetric Center-Aligned PWM Generator

This block produces two pulse-width-modulated reference signals from one shared up/down counter. The counter climbs from zero to a programmable top value and then falls back to zero. That top value alone sets the PWM frequency: one full cycle lasts twice the top value in clocks.

Each reference output belongs to a pair of compare values. The first value of the pair sets the edge while the counter climbs. The second value sets the edge while it falls. Because the value in use is chosen again at every change of direction, the two halves of a period can be shaped separately. Pulse width and pulse placement are therefore independent of each other, and two outputs can be given a programmable phase offset, for example to drive the legs of a phase-shifted bridge.

Each pair has its own 4-bit mode code. The code arrives as two separate pieces, a single upper bit and three lower bits, and is joined before it is decoded. The two asymmetric codes use the up/down compare pair. Two ordinary symmetric codes use only the first compare value of the pair. Every other code parks the output low. The counter value and the counting direction are brought out for observation.

Top module: `asym_cpwm`

## Requirements
- R1: After reset `cnt_o` steps by one each clock from 0 up to `period_i`, then by one back down to 0, and turns around at both ends, so one cycle spans 2·`period_i` clocks. `dir_o` is 0 while climbing and 1 while falling. It becomes 1 on the clock after the count reaches `period_i` and becomes 0 on the clock after the count reaches 0 while falling. With `period_i` = 0 the count stays at 0 and `dir_o` stays 0. A count found above `period_i` while climbing turns downward.
- R2: Output A compares against `cmp_a_up_i` while `dir_o` is 0 and against `cmp_a_dn_i` while `dir_o` is 1. `ref_a_o` after a clock edge reflects the count, direction, compare values and mode that were present before that edge, which is one register stage.
- R3: Output B behaves the same way, using `cmp_b_up_i` while `dir_o` is 0 and `cmp_b_dn_i` while `dir_o` is 1.
- R4: A pair's mode code is {`mode_x_hi_i`, `mode_x_lo_i[2:0]`}, with the upper bit on the left. Code 4'b1110 selects asymmetric mode 1 and code 4'b1111 selects asymmetric mode 2. Each pair decodes its own code independently of the other pair.
- R5: In asymmetric mode 1 the output is 1 while the count is below the selected compare value. Over any run of 2·P steady clocks the high time is clamp(Cup−1, 0, P) + min(Cdn, P).
- R6: Asymmetric mode 2 gives the complement of mode 1 for the same inputs. Its high time is 2·P minus the mode 1 high time.
- R7: In asymmetric mode 1, with both compare values at 0, the output stays 0. With both compare values above `period_i`, the output stays 1.
- R8: Code 4'b0110 is symmetric mode 1 and code 4'b0111 is symmetric mode 2. In both, the up compare value is used in both directions and the down compare value has no effect.
- R9: Any code other than 0110, 0111, 1110 and 1111 holds that pair's output at 0.
- R10: During reset `ref_a_o`, `ref_b_o`, `cnt_o` and `dir_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Counter top value |
| cmp_a_up_i | input | CNT_W | Pair A compare used while climbing |
| cmp_a_dn_i | input | CNT_W | Pair A compare used while falling |
| cmp_b_up_i | input | CNT_W | Pair B compare used while climbing |
| cmp_b_dn_i | input | CNT_W | Pair B compare used while falling |
| mode_a_lo_i | input | 3 | Pair A mode code, lower three bits |
| mode_a_hi_i | input | 1 | Pair A mode code, upper bit |
| mode_b_lo_i | input | 3 | Pair B mode code, lower three bits |
| mode_b_hi_i | input | 1 | Pair B mode code, upper bit |
| ref_a_o | output | 1 | Pair A reference output |
| ref_b_o | output | 1 | Pair B reference output |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | Counting direction (0 climbing, 1 falling) |

## Verification
The hardest case to reach is a mis-joined mode code. If the upper bit were dropped or misplaced, codes 0110 and 1110 would look alike, and the difference only appears when the two compare values of a pair differ. The stimulus therefore walks all sixteen codes with unequal up and down compare values and compares the measured high time of each code against the formula for that code. It also follows the output clock by clock against a prediction built from the observed count and direction, which pins the edge positions within each half period.

// File: rtl/asym_cpwm_pkg.sv
package asym_cpwm_pkg;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'd0,
        SEL_SYM  = 2'd1,
        SEL_ASYM = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e kind;
        logic      invert;
    } mode_dec_t;

    localparam logic [3:0] CODE_SYM1  = 4'b0110;
    localparam logic [3:0] CODE_SYM2  = 4'b0111;
    localparam logic [3:0] CODE_ASYM1 = 4'b1110;
    localparam logic [3:0] CODE_ASYM2 = 4'b1111;

    function automatic mode_dec_t decode_mode(input logic hi, input logic [2:0] lo);
        mode_dec_t  d;
        logic [3:0] code;
        code     = {hi, lo};
        d.kind   = SEL_OFF;
        d.invert = 1'b0;
        unique case (code)
            CODE_SYM1:  d.kind = SEL_SYM;
            CODE_SYM2:  begin d.kind = SEL_SYM;  d.invert = 1'b1; end
            CODE_ASYM1: d.kind = SEL_ASYM;
            CODE_ASYM2: begin d.kind = SEL_ASYM; d.invert = 1'b1; end
            default:    d.kind = SEL_OFF;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cpwm_updown_cnt.sv
module cpwm_updown_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_i == '0) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (!st_q.down) begin
            if (st_q.cnt >= period_i) begin
                st_d.cnt  = st_q.cnt - ONE;
                st_d.down = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt + ONE;
            end
        end else begin
            if (st_q.cnt == '0) begin
                st_d.cnt  = ONE;
                st_d.down = 1'b0;
            end else begin
                st_d.cnt  = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign dir_o = st_q.down;

endmodule

// File: rtl/cpwm_pair_cmp.sv
module cpwm_pair_cmp
    import asym_cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             down_i,
    input  logic [CNT_W-1:0] cmp_up_i,
    input  logic [CNT_W-1:0] cmp_dn_i,
    input  logic             mode_hi_i,
    input  logic [2:0]       mode_lo_i,
    output logic             ref_o
);

    typedef struct packed {
        logic ref_out;
    } pair_state_t;

    pair_state_t      st_d, st_q;
    mode_dec_t        dec;
    logic [CNT_W-1:0] sel_cmp;
    logic             below;

    always_comb begin
        dec     = decode_mode(mode_hi_i, mode_lo_i);
        // asymmetric codes swap compare value with direction; symmetric keep the up one
        sel_cmp = (dec.kind == SEL_ASYM && down_i) ? cmp_dn_i : cmp_up_i;
        below   = (cnt_i < sel_cmp);
        st_d    = st_q;
        if (dec.kind == SEL_OFF) st_d.ref_out = 1'b0;
        else                     st_d.ref_out = below ^ dec.invert;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ref_o = st_q.ref_out;

endmodule

// File: rtl/asym_cpwm.sv
module asym_cpwm #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmp_a_up_i,
    input  logic [CNT_W-1:0] cmp_a_dn_i,
    input  logic [CNT_W-1:0] cmp_b_up_i,
    input  logic [CNT_W-1:0] cmp_b_dn_i,
    input  logic [2:0]       mode_a_lo_i,
    input  logic             mode_a_hi_i,
    input  logic [2:0]       mode_b_lo_i,
    input  logic             mode_b_hi_i,
    output logic             ref_a_o,
    output logic             ref_b_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o
);

    localparam int NPAIR = 2;

    logic [CNT_W-1:0]            cnt;
    logic                        down;
    logic [NPAIR-1:0][CNT_W-1:0] cup, cdn;
    logic [NPAIR-1:0][2:0]       mlo;
    logic [NPAIR-1:0]            mhi;
    logic [NPAIR-1:0]            refs;

    assign cup = {cmp_b_up_i, cmp_a_up_i};
    assign cdn = {cmp_b_dn_i, cmp_a_dn_i};
    assign mlo = {mode_b_lo_i, mode_a_lo_i};
    assign mhi = {mode_b_hi_i, mode_a_hi_i};

    cpwm_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .period_i (period_i),
        .cnt_o    (cnt),
        .dir_o    (down)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        cpwm_pair_cmp #(.CNT_W(CNT_W)) u_pair (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .cnt_i     (cnt),
            .down_i    (down),
            .cmp_up_i  (cup[p]),
            .cmp_dn_i  (cdn[p]),
            .mode_hi_i (mhi[p]),
            .mode_lo_i (mlo[p]),
            .ref_o     (refs[p])
        );
    end

    assign ref_a_o = refs[0];
    assign ref_b_o = refs[1];
    assign cnt_o   = cnt;
    assign dir_o   = down;

endmodule

// File: rtl/asym_cpwm_chk.sv
module asym_cpwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] period_i,
    input logic [CNT_W-1:0] cmp_a_up_i,
    input logic [CNT_W-1:0] cmp_a_dn_i,
    input logic [CNT_W-1:0] cmp_b_up_i,
    input logic [CNT_W-1:0] cmp_b_dn_i,
    input logic [2:0]       mode_a_lo_i,
    input logic             mode_a_hi_i,
    input logic [2:0]       mode_b_lo_i,
    input logic             mode_b_hi_i,
    input logic             ref_a_o,
    input logic             ref_b_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic             dir_o
);

    logic [3:0] code_a, code_b;
    logic       a_valid;
    assign code_a  = {mode_a_hi_i, mode_a_lo_i};
    assign code_b  = {mode_b_hi_i, mode_b_lo_i};
    assign a_valid = (code_a == 4'b0110) || (code_a == 4'b0111) ||
                     (code_a == 4'b1110) || (code_a == 4'b1111);

    a_r1_top_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dir_o && period_i != '0 && cnt_o == period_i)
        |=> (dir_o && cnt_o == $past(cnt_o) - CNT_W'(1)));

    a_r1_bottom_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dir_o && cnt_o == '0 && period_i != '0)
        |=> (!dir_o && cnt_o == CNT_W'(1)));

    a_r1_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i == '0) |=> (cnt_o == '0 && !dir_o));

    a_r1_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o <= period_i) |=> (cnt_o <= $past(period_i)));

    a_r7_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_a == 4'b1110 && cmp_a_up_i == '0 && cmp_a_dn_i == '0) |=> !ref_a_o);

    a_r7_full_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_b == 4'b1110 && cmp_b_up_i > period_i && cmp_b_dn_i > period_i
         && cnt_o <= period_i) |=> ref_b_o);

    a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !a_valid |=> !ref_a_o);

    a_r10_reset: assert property (@(posedge clk_i)
        !rst_ni |=> (!ref_a_o && !ref_b_o && cnt_o == '0 && !dir_o));

endmodule

bind asym_cpwm asym_cpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_i    (period_i),
    .cmp_a_up_i  (cmp_a_up_i),
    .cmp_a_dn_i  (cmp_a_dn_i),
    .cmp_b_up_i  (cmp_b_up_i),
    .cmp_b_dn_i  (cmp_b_dn_i),
    .mode_a_lo_i (mode_a_lo_i),
    .mode_a_hi_i (mode_a_hi_i),
    .mode_b_lo_i (mode_b_lo_i),
    .mode_b_hi_i (mode_b_hi_i),
    .ref_a_o     (ref_a_o),
    .ref_b_o     (ref_b_o),
    .cnt_o       (cnt_o),
    .dir_o       (dir_o)
);

// File: tb/sim_asym_cpwm.sv
module sim_asym_cpwm;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NV         = 6;

    // table: period, A up/dn, B up/dn, codes, expected high clocks per 2*period
    localparam int VP  [NV] = '{10, 10, 10, 10, 10, 6};
    localparam int VAU [NV] = '{ 4,  0, 10,  3,  5, 3};
    localparam int VAD [NV] = '{ 7,  0, 10,  9,  1, 5};
    localparam int VBU [NV] = '{ 2, 11,  6,  4,  5, 7};
    localparam int VBD [NV] = '{ 5, 12,  1,  4,  9, 0};
    localparam int VMA [NV] = '{14, 14, 14,  7,  6, 14};
    localparam int VMB [NV] = '{15, 14,  6,  0,  7, 15};
    localparam int EHA [NV] = '{10,  0, 19, 15,  9, 7};
    localparam int EHB [NV] = '{14, 20, 11,  0, 11, 6};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] period = '0;
    logic [W-1:0] cau = '0, cad = '0, cbu = '0, cbd = '0;
    logic [2:0]   mal = '0, mbl = '0;
    logic         mah = 1'b0, mbh = 1'b0;
    logic         ref_a, ref_b, dir;
    logic [W-1:0] cnt;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asym_cpwm #(.CNT_W(W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .period_i(period),
        .cmp_a_up_i(cau), .cmp_a_dn_i(cad), .cmp_b_up_i(cbu), .cmp_b_dn_i(cbd),
        .mode_a_lo_i(mal), .mode_a_hi_i(mah), .mode_b_lo_i(mbl), .mode_b_hi_i(mbh),
        .ref_a_o(ref_a), .ref_b_o(ref_b), .cnt_o(cnt), .dir_o(dir)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // high clocks over one 2P window, from R5, R6, R8, R9
    function automatic int exp_high(input int code, input int cu, input int cd, input int p);
        int m1s, m1a;
        m1a = clampi(cu - 1, 0, p) + clampi(cd, 0, p);
        m1s = clampi(cu - 1, 0, p) + clampi(cu, 0, p);
        case (code)
            14:      return m1a;
            15:      return 2 * p - m1a;
            6:       return m1s;
            7:       return 2 * p - m1s;
            default: return 0;
        endcase
    endfunction

    // next output from the observed count/direction, from R2, R3, R5, R6, R8, R9
    function automatic bit pred(input int code, input int cu, input int cd,
                                input int c, input bit down);
        int sel;
        bit lt;
        sel = (code >= 14 && down) ? cd : cu;
        lt  = (c < sel);
        case (code)
            14, 6:   return lt;
            15, 7:   return !lt;
            default: return 1'b0;
        endcase
    endfunction

    task automatic set_cfg(input int p, input int au, input int ad, input int bu,
                           input int bd, input int ma, input int mb);
        period = W'(p); cau = W'(au); cad = W'(ad); cbu = W'(bu); cbd = W'(bd);
        {mah, mal} = 4'(ma);
        {mbh, mbl} = 4'(mb);
    endtask

    task automatic measure(input int p, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (40) @(negedge clk);
        for (int k = 0; k < 2 * p; k++) begin
            @(negedge clk);
            ha += int'(ref_a);
            hb += int'(ref_b);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int ha, hb, pa, pb;
        set_cfg(10, 4, 7, 2, 5, 14, 15);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 ref_a", int'(ref_a), 0);
        check("R10 ref_b", int'(ref_b), 0);
        check("R10 cnt",   int'(cnt),   0);
        check("R10 dir",   int'(dir),   0);
        rst_n = 1'b1;

        // R1 count sequence from reset: step k -> k up to P, then 2P-k falling
        for (int k = 0; k <= 21; k++) begin
            if (k > 0) @(negedge clk);
            check("R1 cnt", int'(cnt), (k <= 10) ? k : ((k <= 20) ? 20 - k : k - 20));
            check("R1 dir", int'(dir), (k >= 11 && k <= 20) ? 1 : 0);
        end

        // table walk: R4 R5 R6 R7 R8 (R4 split join: row 4 uses lo=110/111 with hi=0)
        for (int v = 0; v < NV; v++) begin
            set_cfg(VP[v], VAU[v], VAD[v], VBU[v], VBD[v], VMA[v], VMB[v]);
            measure(VP[v], ha, hb);
            check("R2/R4/R5 high time A", ha, EHA[v]);
            check("R3/R4/R6 high time B", hb, EHB[v]);
        end

        // R2 R3 edge placement, clock by clock against observed count/direction
        set_cfg(10, 4, 7, 2, 5, 14, 15);
        repeat (30) @(negedge clk);
        pa = int'(pred(14, 4, 7, int'(cnt), dir));
        pb = int'(pred(15, 2, 5, int'(cnt), dir));
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            check("R2 edge A", int'(ref_a), pa);
            check("R3 edge B", int'(ref_b), pb);
            pa = int'(pred(14, 4, 7, int'(cnt), dir));
            pb = int'(pred(15, 2, 5, int'(cnt), dir));
        end

        // R4 R8 R9 all sixteen codes on both pairs, unequal compares
        for (int c = 0; c < 16; c++) begin
            set_cfg(8, 3, 6, 6, 2, c, 15 - c);
            measure(8, ha, hb);
            check("R4/R8/R9 code sweep A", ha, exp_high(c, 3, 6, 8));
            check("R4/R8/R9 code sweep B", hb, exp_high(15 - c, 6, 2, 8));
        end

        // R7 long windows: all-low and all-high
        set_cfg(12, 0, 0, 13, 20, 14, 14);
        repeat (30) @(negedge clk);
        ha = 0; hb = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            ha += int'(ref_a);
            hb += int'(ref_b);
        end
        check("R7 zero compares stay low", ha, 0);
        check("R7 above-period compares stay high", hb, 100);

        // R1 zero period holds count at 0, climbing
        set_cfg(0, 3, 3, 3, 3, 14, 14);
        repeat (20) @(negedge clk);
        check("R1 zero period cnt", int'(cnt), 0);
        check("R1 zero period dir", int'(dir), 0);

        // R1 shrink period while count is above new top
        set_cfg(15, 3, 3, 3, 3, 14, 14);
        repeat (12) @(negedge clk);
        set_cfg(4, 3, 3, 3, 3, 14, 14);
        repeat (30) @(negedge clk);
        check("R1 recovered below new top", int'(cnt <= 4), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule